// File: doc/BRIEF.md
# Standalone PRBS Bit-Error Checker for Six Receive Lanes

This block sits behind six 10-bit receive lanes and runs a bit-error test on any one of them or on all of them together. Traffic keeps moving on every lane that is not under test. A filtered activate pin and a 3-bit lane code pick the lanes to test. Each tested lane compares its incoming words against a local PRBS-15 (x^15+x^14+1) reference, which synchronises itself from the incoming stream. The lane reports mismatches on its own data outputs, and its lock output is held low for as long as the test runs.

Error reporting has two modes. Gross mode is the default. In gross mode the first word error turns all ten outputs of the lane to ones, and they stay at ones until the test is switched off. In bit mode each output shows whether its own bit position mismatched in the word just checked.

A separate one-cycle start pulse launches a fixed-length run on all six lanes at once, such as a scan-triggered run would need. At the end of the run the block packs a completion flag and a pass flag for each lane into a 12-bit result. A lane passes when its error count stays under one error in ten million checked bits.

The receive words arrive on every clock and cannot be stalled, so no port has a ready or valid handshake. Every lane output is registered, with one cycle of latency.

Top module: `prbs_bist_ctrl`

## Requirements
- R1: A new level on `act_i` takes effect only after `act_i` has held that level for 4 consecutive clock edges. This rule applies both when turning the test on and when turning it off. Shorter pulses change nothing.
- R2: While active, `sel_i` codes 0 to 5 put only lane k = code under test, code 6 puts all six lanes under test, and code 7 puts none under test. While inactive, no lane is under test whatever the code.
- R3: The lock output of a lane under test is low in the cycle after each clock edge at which the lane is under test.
- R4: With `bitmode_i` = 0 (gross mode), a lane under test outputs all zeros while its words match. After the first mismatching word it outputs all ones (10'h3FF), and it keeps them until the lane leaves test.
- R5: With `bitmode_i` = 1, output bit i of a lane under test is 1 exactly when bit i of the word sampled at the previous edge mismatched, and it returns to 0 on the next matching word.
- R6: The reference is PRBS-15 with the rule b[n] = b[n-14] XOR b[n-15]. Word bit 0 is the earliest serial bit. The first two words after a lane enters test seed the generator and are never checked. From the third word on, the generator runs freely and advances 10 bits per word.
- R7: A lane not under test presents its `rx_data_i` word and its `rx_lock_i` bit on its outputs one cycle later, unchanged.
- R8: A high `run_start_i` while no run is in progress clears `result_o` and checks all lanes for `RUN_WORDS` words. One cycle after the last word, bit 2k+1 (complete) of `result_o` is 1 and bit 2k (pass) is 1 when lane k counted at most floor((RUN_WORDS*10-1)/10^7) bit errors. Lane 5 occupies the top two bits.
- R9: During reset, `out_data_o` and `out_lock_o` are all ones and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | 1 | Test activate level, filtered over 4 edges |
| sel_i | input | 3 | Lane code: 0-5 single lane, 6 all, 7 none |
| bitmode_i | input | 1 | 0 gross error report, 1 per-bit report |
| run_start_i | input | 1 | Starts a fixed-length all-lane run |
| rx_data_i | input | 60 | Received words, lane k in bits 10k+9:10k |
| rx_lock_i | input | 6 | Receive lock per lane, low = locked |
| out_data_o | output | 60 | Lane output words (traffic or error report) |
| out_lock_o | output | 6 | Lane lock outputs |
| result_o | output | 12 | Packed complete/pass flags per lane |

## Verification
The bench drives a 3-cycle activate pulse and expects no lane to change. If the filter were off by one, that pulse would pull a lock low. It then checks that the output changes exactly at the fifth edge after activation and not at the fourth. One word error in gross mode must leave the lane at 3FF over the clean words that follow: a non-sticky flag would fall back to zero. In bit mode each lane gets a different single-bit error, and the bench expects exactly that bit and a clean word after it, which exposes both lane mix-ups and stickiness. A full run with one error on lane 3 must clear pass bit 6 only. The bench checks `result_o` both one cycle before and exactly at completion, which catches a misplaced bit or a final word left out of the count.

// File: rtl/prbs_bist_pkg.sv
package prbs_bist_pkg;
  localparam int unsigned NCH    = 6;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned PRBS_W = 15;

  typedef struct packed {
    logic [PRBS_W-1:0] hist;
    logic [WORD_W-1:0] word;
  } prbs_step_t;

  // Advance one word: predicted word out, history fed either from the
  // received bits (seeding) or from the generator itself (free-run).
  function automatic prbs_step_t prbs_advance(input logic [PRBS_W-1:0] h_in,
                                              input logic [WORD_W-1:0] rx,
                                              input logic load);
    prbs_step_t r;
    logic [PRBS_W-1:0] h;
    logic nb;
    h = h_in;
    r.word = '0;
    for (int i = 0; i < WORD_W; i++) begin
      nb = h[13] ^ h[14];
      r.word[i] = nb;
      h = {h[PRBS_W-2:0], load ? rx[i] : nb};
    end
    r.hist = h;
    return r;
  endfunction
endpackage

// File: rtl/act_filter.sv
module act_filter #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_i,
  output logic state_o
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_o <= 1'b0;
      cnt     <= '0;
    end else if (a_i == state_o) begin
      cnt <= '0;
    end else if (cnt == CW'(HOLD - 1)) begin
      state_o <= a_i;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sel_decode.sv
module sel_decode
  import prbs_bist_pkg::*;
#(
  parameter int unsigned LANES = NCH
) (
  input  logic             act_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [LANES-1:0] en_o
);
  localparam logic [SEL_W-1:0] ALL_CODE = SEL_W'(LANES);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign en_o[k] = act_i && ((sel_i == SEL_W'(k)) || (sel_i == ALL_CODE));
  end
endmodule

// File: rtl/run_ctrl.sv
module run_ctrl #(
  parameter int unsigned RUN_WORDS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic running_o,
  output logic clr_o,
  output logic fin_o
);
  localparam int unsigned WC = (RUN_WORDS > 1) ? $clog2(RUN_WORDS) : 1;
  logic [WC-1:0] wcnt;

  assign clr_o = start_i && !running_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_o <= 1'b0;
      wcnt      <= '0;
      fin_o     <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (running_o) begin
        if (wcnt == WC'(RUN_WORDS - 1)) begin
          running_o <= 1'b0;
          fin_o     <= 1'b1;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end else if (start_i) begin
        running_o <= 1'b1;
        wcnt      <= '0;
      end
    end
  end
endmodule

// File: rtl/lane_checker.sv
module lane_checker
  import prbs_bist_pkg::*;
#(
  parameter int unsigned ERRW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en_i,
  input  logic              show_i,
  input  logic              bitmode_i,
  input  logic              cnt_en_i,
  input  logic              cnt_clr_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_lock_i,
  output logic [WORD_W-1:0] out_word_o,
  output logic              out_lock_o,
  output logic [ERRW-1:0]   err_cnt_o
);
  localparam logic [1:0] PH_CHECK = 2'd2;

  logic [PRBS_W-1:0] hist;
  logic [1:0]        phase;
  logic              gross;
  prbs_step_t        nxt;
  logic              checking;
  logic [WORD_W-1:0] err;
  logic              gross_n;
  logic [ERRW-1:0]   pop;

  always_comb begin
    nxt      = prbs_advance(hist, rx_word_i, phase != PH_CHECK);
    checking = chk_en_i && (phase == PH_CHECK);
    err      = checking ? (rx_word_i ^ nxt.word) : '0;
    gross_n  = gross | (|err);
    pop      = ERRW'($countones(err));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist       <= '0;
      phase      <= '0;
      gross      <= 1'b0;
      out_word_o <= '1;
      out_lock_o <= 1'b1;
      err_cnt_o  <= '0;
    end else begin
      if (!chk_en_i) begin
        phase <= '0;
        gross <= 1'b0;
      end else begin
        hist  <= nxt.hist;
        gross <= gross_n;
        if (phase != PH_CHECK) phase <= phase + 1'b1;
      end
      out_lock_o <= show_i ? 1'b0 : rx_lock_i;
      if (!show_i)        out_word_o <= rx_word_i;
      else if (bitmode_i) out_word_o <= err;
      else                out_word_o <= {WORD_W{gross_n}};
      if (cnt_clr_i)                 err_cnt_o <= '0;
      else if (cnt_en_i && checking) err_cnt_o <= err_cnt_o + pop;
    end
  end
endmodule

// File: rtl/prbs_bist_ctrl.sv
module prbs_bist_ctrl
  import prbs_bist_pkg::*;
#(
  parameter int unsigned RUN_WORDS = 64,
  parameter int unsigned ACT_HOLD  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    act_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic                    bitmode_i,
  input  logic                    run_start_i,
  input  logic [NCH*WORD_W-1:0]   rx_data_i,
  input  logic [NCH-1:0]          rx_lock_i,
  output logic [NCH*WORD_W-1:0]   out_data_o,
  output logic [NCH-1:0]          out_lock_o,
  output logic [2*NCH-1:0]        result_o
);
  localparam longint unsigned RUN_BITS  = longint'(RUN_WORDS) * WORD_W;
  localparam longint unsigned ERR_LIMIT = (RUN_BITS - 1) / 64'd10_000_000;
  localparam int unsigned     ERRW      = $clog2(RUN_BITS + 1);

  logic            act_q;
  logic [NCH-1:0]  bist_en;
  logic            running, run_clr, run_fin;
  logic [ERRW-1:0] errc [NCH];

  act_filter #(.HOLD(ACT_HOLD)) u_filt (
    .clk(clk), .rst_n(rst_n), .a_i(act_i), .state_o(act_q)
  );

  sel_decode #(.LANES(NCH)) u_dec (
    .act_i(act_q), .sel_i(sel_i), .en_o(bist_en)
  );

  run_ctrl #(.RUN_WORDS(RUN_WORDS)) u_run (
    .clk(clk), .rst_n(rst_n), .start_i(run_start_i),
    .running_o(running), .clr_o(run_clr), .fin_o(run_fin)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    lane_checker #(.ERRW(ERRW)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .chk_en_i(running | bist_en[k]),
      .show_i(bist_en[k]),
      .bitmode_i(bitmode_i),
      .cnt_en_i(running),
      .cnt_clr_i(run_clr),
      .rx_word_i(rx_data_i[k*WORD_W +: WORD_W]),
      .rx_lock_i(rx_lock_i[k]),
      .out_word_o(out_data_o[k*WORD_W +: WORD_W]),
      .out_lock_o(out_lock_o[k]),
      .err_cnt_o(errc[k])
    );

    always_ff @(posedge clk) begin
      if (!rst_n || run_clr) begin
        result_o[2*k+1 -: 2] <= 2'b00;
      end else if (run_fin) begin
        result_o[2*k+1] <= 1'b1;
        result_o[2*k]   <= (64'(errc[k]) <= ERR_LIMIT);
      end
    end
  end
endmodule

// File: rtl/prbs_bist_ctrl_chk.sv
module prbs_bist_ctrl_chk
  import prbs_bist_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  act_i,
  input logic                  act_state,
  input logic                  bitmode_i,
  input logic [NCH-1:0]        bist_en,
  input logic [NCH*WORD_W-1:0] rx_data_i,
  input logic [NCH-1:0]        rx_lock_i,
  input logic [NCH*WORD_W-1:0] out_data_o,
  input logic [NCH-1:0]        out_lock_o
);
  a_r1_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_state) |-> ($past(act_i, 1) && $past(act_i, 2) &&
                          $past(act_i, 3) && $past(act_i, 4)));

  a_r1_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_state) |-> (!$past(act_i, 1) && !$past(act_i, 2) &&
                          !$past(act_i, 3) && !$past(act_i, 4)));

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    a_r3_lock_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bist_en[k])) |-> !out_lock_o[k]);

    a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(bist_en[k])) |->
        (out_lock_o[k] == $past(rx_lock_i[k]) &&
         out_data_o[k*WORD_W +: WORD_W] == $past(rx_data_i[k*WORD_W +: WORD_W])));

    a_r4_gross_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(bist_en[k], 1) && $past(bist_en[k], 2) &&
       !$past(bitmode_i) && ($past(out_data_o[k*WORD_W +: WORD_W]) == '1))
        |-> (out_data_o[k*WORD_W +: WORD_W] == '1));
  end
endmodule

bind prbs_bist_ctrl prbs_bist_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .act_i(act_i), .act_state(act_q),
  .bitmode_i(bitmode_i), .bist_en(bist_en), .rx_data_i(rx_data_i),
  .rx_lock_i(rx_lock_i), .out_data_o(out_data_o), .out_lock_o(out_lock_o)
);

// File: tb/sim_prbs_bist_ctrl.sv
`timescale 1ns/1ps
module sim_prbs_bist_ctrl;
  localparam int RUN = 40;
  localparam int NL  = 6;
  localparam int WW  = 10;

  typedef struct packed {
    logic [2:0] sel;
    logic [5:0] lk;
  } vec_t;

  // Lane code -> expected lock outputs while active with all rx locks high.
  localparam vec_t VEC [8] = '{
    '{3'd0, 6'b111110}, '{3'd1, 6'b111101}, '{3'd2, 6'b111011},
    '{3'd3, 6'b110111}, '{3'd4, 6'b101111}, '{3'd5, 6'b011111},
    '{3'd6, 6'b000000}, '{3'd7, 6'b111111}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic act, bitmode, run;
  logic [2:0] sel;
  logic [NL*WW-1:0] rx_data, out_data;
  logic [NL-1:0] rx_lock, out_lock;
  logic [2*NL-1:0] result;
  logic [WW-1:0] inj [NL];
  logic [14:0] g = 15'h1ACE;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prbs_bist_ctrl #(.RUN_WORDS(RUN)) u0 (
    .clk(clk), .rst_n(rst_n), .act_i(act), .sel_i(sel), .bitmode_i(bitmode),
    .run_start_i(run), .rx_data_i(rx_data), .rx_lock_i(rx_lock),
    .out_data_o(out_data), .out_lock_o(out_lock), .result_o(result)
  );

  task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // Drive the next PRBS word on every lane (with injected flips), then clock once.
  task automatic step();
    logic [WW-1:0] w;
    logic nb;
    for (int i = 0; i < WW; i++) begin
      nb = g[13] ^ g[14];
      w[i] = nb;
      g = {g[13:0], nb};
    end
    for (int k = 0; k < NL; k++) rx_data[k*WW +: WW] = w ^ inj[k];
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clr_inj();
    for (int k = 0; k < NL; k++) inj[k] = '0;
  endtask

  function automatic logic [WW-1:0] lane(input logic [NL*WW-1:0] v, input int k);
    return v[k*WW +: WW];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; act = 0; sel = 3'd7; bitmode = 0; run = 0;
    rx_lock = '1; rx_data = '0;
    clr_inj();
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset data", 64'(out_data), {4'h0, {60{1'b1}}});
    chk("R9 reset lock", 64'(out_lock), 64'h3F);
    chk("R9 reset result", 64'(result), 64'h0);
    rst_n = 1;

    // R7 idle pass-through
    rx_lock = 6'b010110;
    step();
    chk("R7 data passthrough", 64'(out_data), 64'(rx_data));
    chk("R7 lock passthrough", 64'(out_lock), 64'h16);
    rx_lock = '1;

    // R1 glitch of three cycles is ignored
    sel = 3'd2; act = 1;
    steps(3);
    act = 0;
    steps(6);
    chk("R1 short pulse ignored", 64'(out_lock), 64'h3F);

    // R1 activation needs four edges, effect visible the cycle after
    act = 1;
    steps(4);
    chk("R1 not yet active", 64'(out_lock[2]), 64'h1);
    step();
    chk("R1 R3 lane 2 lock low", 64'(out_lock), 64'b111011);
    steps(2);
    chk("R4 R6 clean word gross zero", 64'(lane(out_data, 2)), 64'h0);
    chk("R7 lane 0 still passes", 64'(lane(out_data, 0)), 64'(lane(rx_data, 0)));
    steps(3);
    chk("R6 reference tracks stream", 64'(lane(out_data, 2)), 64'h0);
    inj[2] = 10'h010;
    step();
    clr_inj();
    chk("R4 gross error flagged", 64'(lane(out_data, 2)), 64'h3FF);
    steps(3);
    chk("R4 gross error sticky", 64'(lane(out_data, 2)), 64'h3FF);

    // R2 lane code table
    for (int v = 0; v < 8; v++) begin
      sel = VEC[v].sel;
      step();
      chk($sformatf("R2 R3 code %0d lock", VEC[v].sel), 64'(out_lock), 64'(VEC[v].lk));
    end
    chk("R2 R7 idle code data", 64'(out_data), 64'(rx_data));

    // R1 deactivation also needs four edges
    sel = 3'd2;
    step();
    act = 0;
    steps(4);
    chk("R1 still active", 64'(out_lock[2]), 64'h0);
    step();
    chk("R1 R7 deactivated lock", 64'(out_lock), 64'h3F);
    chk("R1 R7 deactivated data", 64'(out_data), 64'(rx_data));

    // R5 bit mode on all lanes
    bitmode = 1; sel = 3'd6; act = 1;
    steps(5);
    steps(2);
    step();
    chk("R5 R6 clean all lanes", 64'(out_data), 64'h0);
    for (int k = 0; k < NL; k++) inj[k] = 10'(1 << k);
    step();
    clr_inj();
    for (int k = 0; k < NL; k++)
      chk($sformatf("R5 lane %0d bit flag", k), 64'(lane(out_data, k)), 64'(1 << k));
    step();
    chk("R5 flags clear next word", 64'(out_data), 64'h0);
    act = 0;
    steps(6);
    bitmode = 0;

    // R8 fixed-length run with one error on lane 3
    run = 1;
    step();
    run = 0;
    for (int s = 1; s <= RUN; s++) begin
      if (s == 10) inj[3] = 10'h200;
      step();
      clr_inj();
      if (s == 5) chk("R7 run leaves outputs live", 64'(out_lock), 64'h3F);
    end
    chk("R8 result not before end", 64'(result), 64'h0);
    step();
    chk("R8 result packed", 64'(result), 64'hFBF);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule